// File: doc/BRIEF.md
# Peak and Hold Current Chopper

This block is the digital control loop for one channel that drives an inductive load, such as a valve or a coil, through a high-side switch. In regulation mode it first runs a timed peak phase. After that it runs a hold phase at a lower level. In both phases the load current is chopped the same way: when the sensed current crosses the active threshold, the switch opens for a fixed off-interval and then closes again. In plain switching mode the switch simply follows the channel enable.

The analog parts sit outside the block. A comparator reports whether the load current is above the threshold that the block requests. A DAC turns the requested threshold code into a current level. The block receives a peak level code, a hold level code, a peak duration code, an off-interval code and a mode bit. It drives the gate enable and the threshold code. All timing is counted in ticks of about 1 µs, divided down from the system clock. The mode bit is sampled on the first enabled cycle and holds until the channel is disabled.

Top module: `ph_regulator`

## Requirements
- R1: While `rst` is high, and on the first cycle after it, `gate_on` is 0 and `thr_code` is 0, whatever the other inputs are.
- R2: When `chan_en` is 0 at a clock edge, `gate_on` is 0 after that edge. When the channel is enabled again, the peak phase starts over with its full duration.
- R3: When `mode_ph` is 0 as the channel is enabled, `gate_on` goes to 1 one cycle after `chan_en` rises. It stays 1 until the channel is disabled, and `cmp_hi` has no effect on it. `thr_code` shows `peak_code`.
- R4: When `mode_ph` is 1 and `peak_time` is nonzero, `gate_on` goes to 1 one cycle after enable. From that cycle, `thr_code` equals `peak_code` for exactly `peak_time` × PEAK_UNIT × TICK_DIV cycles and then equals `hold_code`. Chopping does not stretch or shorten this duration.
- R5: When `mode_ph` is 1 and `peak_time` is 0, the peak phase is skipped. `thr_code` equals `hold_code` from the first cycle that `gate_on` is 1.
- R6: In regulation mode, if `cmp_hi` is 1 while `gate_on` is 1, `gate_on` is 0 on the next cycle. This holds in both the peak phase and the hold phase.
- R7: Each off-interval lasts exactly (`off_time` + 1) × OFF_UNIT × TICK_DIV cycles. With the default parameters, codes 0 to 3 give 100 µs to 400 µs. After the interval, `gate_on` returns to 1.
- R8: Changes of `cmp_hi` during an off-interval have no effect. The switch closes again only when the off-interval counter expires.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| chan_en | input | 1 | Channel enable; low forces the switch off and returns the controller to idle |
| mode_ph | input | 1 | 1 = peak and hold regulation, 0 = plain on/off switching |
| cmp_hi | input | 1 | Comparator output: load current is at or above the requested threshold |
| peak_code | input | CODE_W | Threshold code used during the peak phase |
| hold_code | input | CODE_W | Threshold code used during the hold phase |
| peak_time | input | PT_W | Peak duration in steps of PEAK_UNIT ticks; 0 skips the peak phase |
| off_time | input | OFF_W | Off-interval as (code + 1) steps of OFF_UNIT ticks |
| gate_on | output | 1 | Registered gate drive enable for the high-side switch |
| thr_code | output | CODE_W | Registered threshold code sent to the current DAC |

## Verification
On every cycle, the assertions check four things:
- a disabled channel always opens the switch;
- in regulation mode, a comparator trip while the switch is closed always opens it on the next cycle;
- an off-interval that ends during a run always lasts between one and four off steps;
- in switching mode, the gate stays closed.

The exact length of the peak phase cannot be seen on any single cycle, so the bench scenarios measure it. They also measure the exact off-interval for each code. The scenarios cover three further cases: the peak timer expiring in the middle of an off-interval, a restart after a mid-phase disable, and comparator activity being ignored during an off-interval. The bench measures these as cycle counts at the ports.

// File: rtl/ph_pkg.sv
package ph_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SWITCH,
    ST_PK_ON,
    ST_PK_OFF,
    ST_HD_ON,
    ST_HD_OFF
  } ph_state_e;

  function automatic logic state_closes_gate(ph_state_e s);
    return (s == ST_SWITCH) || (s == ST_PK_ON) || (s == ST_HD_ON);
  endfunction

  function automatic logic state_is_hold(ph_state_e s);
    return (s == ST_HD_ON) || (s == ST_HD_OFF);
  endfunction

endpackage

// File: rtl/ph_interval_timer.sv
module ph_interval_timer #(
  parameter int TICK_DIV = 50,
  parameter int CNT_W    = 12
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic             clear,
  input  logic [CNT_W-1:0] ticks,
  output logic             fin
);

  localparam int PRE_W = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;
  localparam logic [PRE_W-1:0] PRE_LAST = PRE_W'(TICK_DIV - 1);

  logic             running;
  logic [PRE_W-1:0] pre;
  logic [CNT_W-1:0] left;
  logic             tick;

  assign tick = running && (pre == PRE_LAST);
  assign fin  = tick && (left == CNT_W'(1));

  always_ff @(posedge clk) begin
    if (rst || clear) begin
      running <= 1'b0;
      pre     <= '0;
      left    <= '0;
    end else if (load) begin
      running <= (ticks != '0);
      pre     <= '0;
      left    <= ticks;
    end else if (tick) begin
      pre  <= '0;
      left <= left - CNT_W'(1);
      if (left == CNT_W'(1)) running <= 1'b0;
    end else if (running) begin
      pre <= pre + PRE_W'(1);
    end
  end

endmodule

// File: rtl/ph_chop_fsm.sv
module ph_chop_fsm
  import ph_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  logic      chan_en,
  input  logic      mode_ph,
  input  logic      cmp_hi,
  input  logic      pt_zero,
  input  logic      pk_fin,
  input  logic      off_fin,
  output ph_state_e st_nx,
  output logic      pk_load,
  output logic      off_load,
  output logic      tmr_clr
);

  ph_state_e st;

  always_comb begin
    st_nx    = st;
    pk_load  = 1'b0;
    off_load = 1'b0;
    tmr_clr  = !chan_en;
    if (!chan_en) begin
      st_nx = ST_IDLE;
    end else begin
      case (st)
        ST_IDLE: begin
          if (!mode_ph)     st_nx = ST_SWITCH;
          else if (pt_zero) st_nx = ST_HD_ON;
          else begin
            st_nx   = ST_PK_ON;
            pk_load = 1'b1;
          end
        end
        ST_SWITCH: st_nx = ST_SWITCH;
        ST_PK_ON: begin
          if (cmp_hi) begin
            off_load = 1'b1;
            st_nx    = pk_fin ? ST_HD_OFF : ST_PK_OFF;
          end else if (pk_fin) begin
            st_nx = ST_HD_ON;
          end
        end
        ST_PK_OFF: begin
          if (off_fin)     st_nx = pk_fin ? ST_HD_ON : ST_PK_ON;
          else if (pk_fin) st_nx = ST_HD_OFF;
        end
        ST_HD_ON: begin
          if (cmp_hi) begin
            off_load = 1'b1;
            st_nx    = ST_HD_OFF;
          end
        end
        ST_HD_OFF: begin
          if (off_fin) st_nx = ST_HD_ON;
        end
        default: st_nx = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) st <= ST_IDLE;
    else     st <= st_nx;
  end

endmodule

// File: rtl/ph_regulator.sv
module ph_regulator
  import ph_pkg::*;
#(
  parameter int TICK_DIV  = 50,
  parameter int OFF_UNIT  = 100,
  parameter int PEAK_UNIT = 240,
  parameter int OFF_W     = 2,
  parameter int PT_W      = 4,
  parameter int CODE_W    = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              chan_en,
  input  logic              mode_ph,
  input  logic              cmp_hi,
  input  logic [CODE_W-1:0] peak_code,
  input  logic [CODE_W-1:0] hold_code,
  input  logic [PT_W-1:0]   peak_time,
  input  logic [OFF_W-1:0]  off_time,
  output logic              gate_on,
  output logic [CODE_W-1:0] thr_code
);

  localparam int PK_CNT_W  = $clog2(((1 << PT_W) - 1) * PEAK_UNIT + 1);
  localparam int OFF_CNT_W = $clog2((1 << OFF_W) * OFF_UNIT + 1);

  ph_state_e            st_nx;
  logic                 pk_load, off_load, tmr_clr;
  logic                 pk_fin, off_fin;
  logic [PK_CNT_W-1:0]  pk_ticks;
  logic [OFF_CNT_W-1:0] off_ticks;
  logic                 pt_zero;

  assign pt_zero   = (peak_time == '0);
  assign pk_ticks  = PK_CNT_W'(peak_time) * PK_CNT_W'(PEAK_UNIT);
  assign off_ticks = (OFF_CNT_W'(off_time) + OFF_CNT_W'(1)) * OFF_CNT_W'(OFF_UNIT);

  ph_chop_fsm u_fsm (
    .clk      (clk),
    .rst      (rst),
    .chan_en  (chan_en),
    .mode_ph  (mode_ph),
    .cmp_hi   (cmp_hi),
    .pt_zero  (pt_zero),
    .pk_fin   (pk_fin),
    .off_fin  (off_fin),
    .st_nx    (st_nx),
    .pk_load  (pk_load),
    .off_load (off_load),
    .tmr_clr  (tmr_clr)
  );

  ph_interval_timer #(.TICK_DIV(TICK_DIV), .CNT_W(PK_CNT_W)) u_pk_tmr (
    .clk   (clk),
    .rst   (rst),
    .load  (pk_load),
    .clear (tmr_clr),
    .ticks (pk_ticks),
    .fin   (pk_fin)
  );

  ph_interval_timer #(.TICK_DIV(TICK_DIV), .CNT_W(OFF_CNT_W)) u_off_tmr (
    .clk   (clk),
    .rst   (rst),
    .load  (off_load),
    .clear (tmr_clr),
    .ticks (off_ticks),
    .fin   (off_fin)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      gate_on  <= 1'b0;
      thr_code <= '0;
    end else begin
      gate_on  <= state_closes_gate(st_nx);
      thr_code <= state_is_hold(st_nx) ? hold_code : peak_code;
    end
  end

endmodule

// File: rtl/ph_regulator_chk.sv
module ph_regulator_chk #(
  parameter int TICK_DIV = 50,
  parameter int OFF_UNIT = 100,
  parameter int OFF_W    = 2,
  parameter int CODE_W   = 4
) (
  input logic              clk,
  input logic              rst,
  input logic              chan_en,
  input logic              mode_ph,
  input logic              cmp_hi,
  input logic [CODE_W-1:0] peak_code,
  input logic [CODE_W-1:0] hold_code,
  input logic              gate_on,
  input logic [CODE_W-1:0] thr_code
);

  localparam logic [31:0] OFF_MIN = 32'(OFF_UNIT * TICK_DIV);
  localparam logic [31:0] OFF_MAX = 32'((1 << OFF_W) * OFF_UNIT * TICK_DIV);

  logic        en_q, en_qq, ph_q;
  logic [31:0] lowcnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      en_q   <= 1'b0;
      en_qq  <= 1'b0;
      ph_q   <= 1'b0;
      lowcnt <= '0;
    end else begin
      en_q  <= chan_en;
      en_qq <= en_q;
      if (chan_en && !en_q) ph_q <= mode_ph;
      if (!chan_en || gate_on) lowcnt <= '0;
      else if (lowcnt != '1)   lowcnt <= lowcnt + 32'd1;
    end
  end

  AST_RESET_IDLE: assert property (@(posedge clk)
    rst |=> (!gate_on && thr_code == '0)); // R1

  AST_DISABLE_OPENS: assert property (@(posedge clk) disable iff (rst)
    !chan_en |=> !gate_on); // R2

  AST_RISE_NEEDS_EN: assert property (@(posedge clk) disable iff (rst)
    $rose(gate_on) |-> $past(chan_en)); // R2

  AST_SWITCH_HELD: assert property (@(posedge clk) disable iff (rst)
    (chan_en && en_q && !ph_q) |-> gate_on); // R3

  AST_THR_LEVEL: assert property (@(posedge clk) disable iff (rst)
    (gate_on && $stable(peak_code) && $stable(hold_code))
      |-> (thr_code == peak_code || thr_code == hold_code)); // R4

  AST_CHOP_ON_CMP: assert property (@(posedge clk) disable iff (rst)
    (chan_en && en_q && ph_q && gate_on && cmp_hi) |=> !gate_on); // R6

  AST_OFF_WINDOW: assert property (@(posedge clk) disable iff (rst)
    (chan_en && en_q && en_qq && $rose(gate_on))
      |-> (lowcnt >= OFF_MIN && lowcnt <= OFF_MAX)); // R7

endmodule

bind ph_regulator ph_regulator_chk #(
  .TICK_DIV (TICK_DIV),
  .OFF_UNIT (OFF_UNIT),
  .OFF_W    (OFF_W),
  .CODE_W   (CODE_W)
) u_chk (
  .clk       (clk),
  .rst       (rst),
  .chan_en   (chan_en),
  .mode_ph   (mode_ph),
  .cmp_hi    (cmp_hi),
  .peak_code (peak_code),
  .hold_code (hold_code),
  .gate_on   (gate_on),
  .thr_code  (thr_code)
);

// File: tb/ph_regulator_bench.sv
`timescale 1ns/1ps
module ph_regulator_bench;

  localparam int TICK_DIV  = 2;
  localparam int OFF_UNIT  = 2;
  localparam int PEAK_UNIT = 3;
  localparam int OFF_W     = 2;
  localparam int PT_W      = 4;
  localparam int CODE_W    = 4;
  localparam int PK_STEP   = PEAK_UNIT * TICK_DIV;
  localparam int OFF_STEP  = OFF_UNIT * TICK_DIV;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              chan_en = 1'b0;
  logic              mode_ph = 1'b1;
  logic              cmp_hi = 1'b0;
  logic [CODE_W-1:0] peak_code = 4'hA;
  logic [CODE_W-1:0] hold_code = 4'h3;
  logic [PT_W-1:0]   peak_time = '0;
  logic [OFF_W-1:0]  off_time = '0;
  logic              gate_on;
  logic [CODE_W-1:0] thr_code;

  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  ph_regulator #(
    .TICK_DIV(TICK_DIV), .OFF_UNIT(OFF_UNIT), .PEAK_UNIT(PEAK_UNIT),
    .OFF_W(OFF_W), .PT_W(PT_W), .CODE_W(CODE_W)
  ) u_ph_regulator (
    .clk(clk), .rst(rst), .chan_en(chan_en), .mode_ph(mode_ph), .cmp_hi(cmp_hi),
    .peak_code(peak_code), .hold_code(hold_code), .peak_time(peak_time),
    .off_time(off_time), .gate_on(gate_on), .thr_code(thr_code)
  );

  task automatic step();
    @(posedge clk);
    #2;
  endtask

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic gap();
    chan_en = 1'b0;
    cmp_hi  = 1'b0;
    step();
    step();
  endtask

  task automatic count_peak(output int n);
    n = 0;
    while (thr_code == peak_code && n < 300) begin
      n++;
      step();
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int n, lows, bad, first_hold, first_on, highs;

    // R1: reset holds the outputs cleared even with the channel enabled
    chan_en = 1'b1;
    repeat (3) step();
    chk("R1", "gate_on in reset", int'(gate_on), 0);
    chk("R1", "thr_code in reset", int'(thr_code), 0);
    chan_en = 1'b0;
    rst = 1'b0;
    step();
    chk("R1", "gate_on after reset", int'(gate_on), 0);

    // R3: plain switching ignores the comparator
    mode_ph = 1'b0;
    chan_en = 1'b1;
    step();
    chk("R3", "gate_on after enable", int'(gate_on), 1);
    chk("R3", "thr_code in switch mode", int'(thr_code), int'(peak_code));
    bad = 0;
    for (int i = 0; i < 12; i++) begin
      cmp_hi = i[0];
      step();
      if (!gate_on) bad++;
    end
    chk("R3", "gate drops with comparator", bad, 0);
    chan_en = 1'b0;
    cmp_hi = 1'b0;
    step();
    chk("R2", "gate_on after disable", int'(gate_on), 0);
    gap();

    // R4: peak length for every nonzero code
    mode_ph = 1'b1;
    off_time = '0;
    for (int pt = 1; pt < (1 << PT_W); pt++) begin
      peak_time = PT_W'(pt);
      chan_en = 1'b1;
      step();
      count_peak(n);
      chk("R4", $sformatf("peak cycles code %0d", pt), n, pt * PK_STEP);
      chk("R4", "hold level after peak", int'(thr_code), int'(hold_code));
      gap();
    end

    // R5: zero peak time starts in hold
    peak_time = '0;
    chan_en = 1'b1;
    step();
    chk("R5", "gate_on", int'(gate_on), 1);
    chk("R5", "thr_code is hold", int'(thr_code), int'(hold_code));
    gap();

    // R6/R7: off-interval for every code in the hold phase
    for (int oc = 0; oc < (1 << OFF_W); oc++) begin
      off_time = OFF_W'(oc);
      chan_en = 1'b1;
      step();
      step();
      cmp_hi = 1'b1;
      step();
      cmp_hi = 1'b0;
      chk("R6", "gate opens on comparator", int'(gate_on), 0);
      n = 0;
      while (!gate_on && n < 300) begin
        n++;
        step();
      end
      chk("R7", $sformatf("off cycles code %0d", oc), n, (oc + 1) * OFF_STEP);
      gap();
    end

    // R8: comparator activity inside the off-interval is ignored
    off_time = 2'd3;
    chan_en = 1'b1;
    step();
    cmp_hi = 1'b1;
    step();
    n = 0;
    while (!gate_on && n < 300) begin
      n++;
      cmp_hi = (n >= 2 && n <= 12);
      step();
    end
    cmp_hi = 1'b0;
    chk("R8", "off cycles with comparator toggling", n, 4 * OFF_STEP);
    gap();

    // R4/R6: chopping inside the peak does not change its length
    peak_time = 4'd15;
    off_time = '0;
    chan_en = 1'b1;
    step();
    n = 0;
    lows = 0;
    while (thr_code == peak_code && n < 300) begin
      if (!gate_on) lows++;
      cmp_hi = (n == 10 || n == 40);
      n++;
      step();
    end
    cmp_hi = 1'b0;
    chk("R4", "peak cycles with chopping", n, 15 * PK_STEP);
    chk("R6", "off cycles during peak", lows, 2 * OFF_STEP);
    gap();

    // R4/R7: peak ends while the switch is open
    peak_time = 4'd1;
    off_time = 2'd3;
    chan_en = 1'b1;
    step();
    cmp_hi = 1'b1;
    step();
    cmp_hi = 1'b0;
    first_hold = -1;
    first_on = -1;
    for (int k = 2; k <= 24; k++) begin
      step();
      if (first_hold < 0 && thr_code == hold_code) first_hold = k;
      if (first_on < 0 && gate_on) first_on = k;
    end
    chk("R4", "hold level cycle while open", first_hold, PK_STEP);
    chk("R7", "reclose cycle after peak end", first_on, 1 + 4 * OFF_STEP);
    gap();

    // R2: disable mid-peak, then a full restart
    peak_time = 4'd5;
    off_time = '0;
    chan_en = 1'b1;
    step();
    repeat (10) step();
    chan_en = 1'b0;
    step();
    chk("R2", "gate_on after mid-peak disable", int'(gate_on), 0);
    step();
    chan_en = 1'b1;
    step();
    count_peak(n);
    chk("R2", "restarted peak cycles", n, 5 * PK_STEP);
    gap();

    // R6/R7: comparator held high gives a steady chop
    peak_time = '0;
    off_time = 2'd1;
    chan_en = 1'b1;
    step();
    cmp_hi = 1'b1;
    highs = 0;
    for (int i = 1; i <= 36; i++) begin
      step();
      if (gate_on) highs++;
    end
    chk("R7", "on cycles with comparator held", highs, 36 / (2 * OFF_STEP + 1));
    gap();

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule